// File: doc/BRIEF.md
# Down-Counting Watchdog Timer

This block is a bus-mapped watchdog. Software arms it by writing a tick count into its counter register. From then on the counter drops by one on every tick of the chosen tick source. When the count arrives at 1, the block raises a system reset request for a fixed number of clock cycles. It then clears the counter to 0, so the same expiry cannot fire a second time.

A count of 0 is the idle state and never produces a reset, so writing 0 stops the watchdog. Writing 1 forces a reset on the next clock edge, which software can use as a deliberate restart. To time out after N ticks, software writes N+1.

A configuration word selects between two tick sources. It also holds a disable flag that freezes the counter and suppresses the reset. Software can read the counter at any time to work out how much time is left.

Top module: `wdog_timer`

## Requirements
- R1: The counter is at byte address 0 and the configuration word is at byte address 4. Reads from any other address return 0, and writes to any other address change nothing.
- R2: While the count is above 1 and the disable flag is clear, each cycle with the selected tick lowers the count by exactly one. Cycles without a tick leave it unchanged.
- R3: When the count equals 1 with the disable flag clear and no counter write, the next edge clears the count to 0 and raises the reset request. The request stays high for exactly PULSE_CYCLES clock cycles.
- R4: A count of 0 stays at 0 regardless of ticks, and never raises the reset request. Writing 0 stops a running count.
- R5: Writing 1 to the counter raises the reset request one clock edge after the write.
- R6: A read of the counter returns the live count.
- R7: Configuration bit 0 set selects the tick_xtal input, and clear selects the tick_alt input. The unselected input has no effect.
- R8: While configuration bit 31 is set, the count holds its value and no reset request begins. Clearing the bit resumes normal operation.
- R9: A counter write in the same cycle as a tick or an expiry wins: the written value is loaded and no reset begins.
- R10: Configuration bits other than 0 and 31 ignore writes and read back as 0.
- R11: After reset, the counter, the configuration word and the reset request are all 0.
- R12: Writing N+1 with the selected tick present makes the count reach 1 after exactly N ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| tick_xtal | input | 1 | Tick enable from the crystal source |
| tick_alt | input | 1 | Tick enable from the alternate source |
| rst_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with its defaults: a 32-bit data path, 3 address bits, combinational tick selection and a 16-cycle reset pulse. The 16-cycle pulse is long enough for the bench to count its exact width at the port. The full-width configuration word lets a write of all ones show that only bits 0 and 31 stick. Small arming values keep every expiry within a handful of ticks, so the bench can step through each decrement, the terminal value, and the cycle in which a write competes with a tick or an expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // byte offsets decoded by the register block
   localparam int unsigned CNT_OFS = 0;
   localparam int unsigned CFG_OFS = 4;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 3,
   parameter int SRC_BIT = 0,
   parameter int DIS_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] count_q,
   output logic              cnt_wr,
   output logic              cfg_src,
   output logic              cfg_dis,
   output logic [DATA_W-1:0] bus_rdata
);
   import wdog_pkg::*;

   localparam logic [DATA_W-1:0] ONE_V    = 1;
   localparam logic [DATA_W-1:0] CFG_MASK = (ONE_V << SRC_BIT) | (ONE_V << DIS_BIT);

   logic              hit_cnt, hit_cfg;
   logic [DATA_W-1:0] cfg_q;

   assign hit_cnt = (bus_addr == ADDR_W'(CNT_OFS));
   assign hit_cfg = (bus_addr == ADDR_W'(CFG_OFS));
   assign cnt_wr  = bus_we & hit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (bus_we && hit_cfg)
         cfg_q <= bus_wdata & CFG_MASK;
   end

   assign cfg_src = cfg_q[SRC_BIT];
   assign cfg_dis = cfg_q[DIS_BIT];

   always_comb begin
      if (hit_cnt)
         bus_rdata = count_q;
      else if (hit_cfg)
         bus_rdata = cfg_q;
      else
         bus_rdata = '0;
   end
endmodule

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
   parameter bit REG_TICK = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_xtal,
   input  logic tick_xtal,
   input  logic tick_alt,
   output logic tick
);
   logic pick;
   assign pick = sel_xtal ? tick_xtal : tick_alt;

   generate
      if (REG_TICK) begin : g_reg
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= pick;
         end
         assign tick = tick_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tick = pick;
      end
   endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tick,
   input  logic              dis,
   output logic [DATA_W-1:0] count_q,
   output logic              fire
);
   localparam logic [DATA_W-1:0] ONE_V = 1;

   logic at_term, above_term;
   assign at_term    = (count_q == ONE_V);
   assign above_term = (count_q > ONE_V);
   assign fire       = !wr && !dis && at_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (wr)
         count_q <= wdata;
      else if (dis)
         count_q <= count_q;
      else if (at_term)
         count_q <= '0;
      else if (above_term && tick)
         count_q <= count_q - ONE_V;
   end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int PULSE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   generate
      if (PULSE_CYCLES == 1) begin : g_flop
         logic p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) p_q <= 1'b0;
            else        p_q <= fire;
         end
         assign pulse = p_q;
      end else begin : g_count
         localparam int PW = $clog2(PULSE_CYCLES + 1);
         localparam logic [PW-1:0] LOAD = PW'(PULSE_CYCLES);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left_q <= '0;
            else if (fire)
               left_q <= LOAD;
            else if (left_q != '0)
               left_q <= left_q - PW'(1);
         end
         assign pulse = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 3,
   parameter int SRC_BIT      = 0,
   parameter int DIS_BIT      = 31,
   parameter int PULSE_CYCLES = 16,
   parameter bit REG_TICK     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_xtal,
   input  logic              tick_alt,
   output logic              rst_req
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("wdog_timer: DATA_W must be at least 2");
      end
      if (ADDR_W < 3) begin : g_bad_a
         $error("wdog_timer: ADDR_W must reach byte offset 4");
      end
      if (SRC_BIT >= DATA_W || DIS_BIT >= DATA_W || SRC_BIT == DIS_BIT) begin : g_bad_b
         $error("wdog_timer: configuration bit positions invalid");
      end
      if (PULSE_CYCLES < 1) begin : g_bad_p
         $error("wdog_timer: PULSE_CYCLES must be at least 1");
      end
   endgenerate

   logic              cnt_wr, sel_xtal, dis, tick, fire;
   logic [DATA_W-1:0] count_q;

   wdog_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_BIT(SRC_BIT), .DIS_BIT(DIS_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .count_q(count_q), .cnt_wr(cnt_wr),
      .cfg_src(sel_xtal), .cfg_dis(dis), .bus_rdata(bus_rdata)
   );

   wdog_tick_sel #(.REG_TICK(REG_TICK)) u_tick (
      .clk(clk), .rst_n(rst_n), .sel_xtal(sel_xtal),
      .tick_xtal(tick_xtal), .tick_alt(tick_alt), .tick(tick)
   );

   wdog_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wdata(bus_wdata),
      .tick(tick), .dis(dis), .count_q(count_q), .fire(fire)
   );

   wdog_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(rst_req)
   );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnt_wr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] count_q,
   input logic              dis,
   input logic              tick,
   input logic              rst_req
);
   assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count_q > DATA_W'(1) && !dis && !cnt_wr) |=> (count_q == $past(count_q) - DATA_W'(1)));

   assert_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == DATA_W'(1) && !dis && !cnt_wr) |=> (rst_req && count_q == '0));

   assert_idle_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0 && !cnt_wr) |=> (count_q == '0));

   assert_pulse_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> ($past(count_q) == DATA_W'(1)));

   assert_disable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dis && !cnt_wr) |=> $stable(count_q));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count_q == $past(wdata)));
endmodule

bind wdog_timer wdog_timer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .wdata(bus_wdata),
   .count_q(count_q), .dis(dis), .tick(tick), .rst_req(rst_req)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PULSE      = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_xtal = 1'b0;
   logic        tick_alt = 1'b0;
   logic        rst_req;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_xtal(tick_xtal),
      .tick_alt(tick_alt), .rst_req(rst_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0; bus_addr = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata; bus_addr = '0;
   endtask

   task automatic tk(input bit xtal, input bit alt);
      tick_xtal = xtal; tick_alt = alt;
      @(posedge clk); @(negedge clk);
      tick_xtal = 1'b0; tick_alt = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic pulse_width(output int w);
      w = 0;
      for (int i = 0; i < PULSE + 8; i++) begin
         if (rst_req) w++;
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(3'd0, v); chk("R11 count after reset", v, 0);
      rd(3'd4, v); chk("R11 config after reset", v, 0);
      chk("R11 rst_req after reset", {31'd0, rst_req}, 0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, v); chk("R10 unused config bits", v, 32'h8000_0001);
      wr(3'd0, 32'h0000_0000);
      wr(3'd4, 32'h0000_0000);
      wr(3'd6, 32'h1234_5678);
      rd(3'd6, v); chk("R1 unmapped read", v, 0);
      rd(3'd0, v); chk("R1 unmapped write count", v, 0);
      rd(3'd4, v); chk("R1 unmapped write config", v, 0);
      wr(3'd4, 32'h8000_0000);
      wr(3'd0, 32'hDEAD_BEEF);
      rd(3'd0, v); chk("R1 count readback", v, 32'hDEAD_BEEF);
      wr(3'd0, 0); wr(3'd4, 0);
   endtask

   task automatic t_alt_src();
      logic [31:0] v;
      wr(3'd4, 32'h0);
      wr(3'd0, 32'd3);
      tk(1'b1, 1'b0);
      rd(3'd0, v); chk("R7 xtal ignored when alt selected", v, 3);
      tk(1'b0, 1'b1);
      rd(3'd0, v); chk("R7 alt tick decrements", v, 2);
      idle(2);
      rd(3'd0, v); chk("R2 no tick no change", v, 2);
      wr(3'd0, 0);
   endtask

   task automatic t_arm();
      logic [31:0] v;
      int w;
      wr(3'd4, 32'h1);
      wr(3'd0, 32'd4);
      tk(1'b1, 1'b0);
      rd(3'd0, v); chk("R6 live count", v, 3);
      tk(1'b0, 1'b1);
      rd(3'd0, v); chk("R7 alt ignored when xtal selected", v, 3);
      tk(1'b1, 1'b0);
      tk(1'b1, 1'b0);
      rd(3'd0, v); chk("R12 reaches 1 after N ticks", v, 1);
      chk("R12 no reset before expiry", {31'd0, rst_req}, 0);
      @(posedge clk); @(negedge clk);
      chk("R3 reset raised", {31'd0, rst_req}, 1);
      rd(3'd0, v); chk("R3 count cleared", v, 0);
      pulse_width(w);
      chk("R3 pulse width", w, PULSE);
      idle(4);
      chk("R3 no retrigger", {31'd0, rst_req}, 0);
   endtask

   task automatic t_force();
      logic [31:0] v;
      int w;
      wr(3'd0, 32'd1);
      chk("R5 not yet", {31'd0, rst_req}, 0);
      @(posedge clk); @(negedge clk);
      chk("R5 forced reset", {31'd0, rst_req}, 1);
      pulse_width(w);
      chk("R5 pulse width", w, PULSE);
      rd(3'd0, v); chk("R5 count idle after", v, 0);
   endtask

   task automatic t_stop();
      logic [31:0] v;
      int w;
      wr(3'd4, 32'h1);
      wr(3'd0, 32'd5);
      tk(1'b1, 1'b0);
      wr(3'd0, 32'd0);
      for (int i = 0; i < 3; i++) tk(1'b1, 1'b1);
      rd(3'd0, v); chk("R4 stopped stays zero", v, 0);
      pulse_width(w);
      chk("R4 no reset from zero", w, 0);
   endtask

   task automatic t_disable();
      logic [31:0] v;
      int w;
      wr(3'd4, 32'h8000_0001);
      wr(3'd0, 32'd5);
      tk(1'b1, 1'b0);
      rd(3'd0, v); chk("R8 tick frozen", v, 5);
      wr(3'd0, 32'd1);
      pulse_width(w);
      chk("R8 no reset while disabled", w, 0);
      rd(3'd0, v); chk("R8 count held at 1", v, 1);
      wr(3'd4, 32'h1);
      @(posedge clk); @(negedge clk);
      chk("R8 fires after enable", {31'd0, rst_req}, 1);
      idle(PULSE + 2);
   endtask

   task automatic t_priority();
      logic [31:0] v;
      int w;
      wr(3'd4, 32'h1);
      wr(3'd0, 32'd10);
      tick_xtal = 1'b1;
      wr(3'd0, 32'd7);
      tick_xtal = 1'b0;
      rd(3'd0, v); chk("R9 write beats tick", v, 7);
      wr(3'd0, 32'd1);
      wr(3'd0, 32'd9);
      rd(3'd0, v); chk("R9 write beats expiry", v, 9);
      pulse_width(w);
      chk("R9 no reset on overwritten expiry", w, 0);
      wr(3'd0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_alt_src();
      t_arm();
      t_force();
      t_stop();
      t_disable();
      t_priority();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule